// File: doc/BRIEF.md
# Periodic Down-Count Timer with Sticky Interrupt

This block is a programmable 16-bit down-counter that steps once per 100 microsecond tick, the tick being produced by an internal prescaler that divides the system clock. Software reaches it through simple per-field write strobes and reads the current state back from plain outputs. The fields are an on/off control bit, a 16-bit pre-load value, the live count, a sticky event status bit and an interrupt enable bit.

Turning the timer on copies the pre-load value into the count. Each tick after that lowers the count by one. A tick taken while the count is zero makes the count all-ones (it does not reload the pre-load), sets the sticky status bit, and counting goes on. Writing a new pre-load while the timer runs restarts the count from that value. Turning the timer off returns the pre-load to all-ones and freezes the count. The level interrupt request is the status bit gated by the enable bit. The status bit is cleared by writing a one to it.

Top module: `pdt_timer`

## Requirements
- R1: After a synchronous active-low reset: count = 16'hFFFF, pre-load = 16'hFFFF, on-bit = 0, status = 0, interrupt enable = 0, irq = 0.
- R2: A write of 1 to the on-bit while it is 0 loads the count from the pre-load field. The new count is visible in the cycle after the write edge.
- R3: While on, the count drops by one every TICK_DIV clock cycles. The prescaler restarts on every load, so the first decrement happens TICK_DIV edges after the load edge.
- R4: A pre-load write while the timer is on stores the value and restarts the count (and prescaler) from it. While off, a pre-load write stores only the value and leaves the count unchanged.
- R5: A tick taken at count 0 moves the count to 16'hFFFF, not to the pre-load value, and decrementing continues from there.
- R6: The tick that wraps the count sets the status bit. Status stays set until a status write with data 1. A status write with data 0 has no effect.
- R7: When a wrap and a status write-one-to-clear fall on the same edge, the status ends set.
- R8: irq is 1 exactly when both status and interrupt enable are 1.
- R9: A write of 0 to the on-bit while it is 1 sets the pre-load to 16'hFFFF and freezes the count. While off, no tick occurs and status is never set.
- R10: If the timer is switched off and the pre-load is written on the same edge, the pre-load ends as 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_wr | input | 1 | Write strobe for the on-bit |
| on_wdata | input | 1 | Value written to the on-bit |
| pre_wr | input | 1 | Write strobe for the pre-load field |
| pre_wdata | input | CNT_W | Value written to the pre-load field |
| sts_wr | input | 1 | Write strobe for the status bit (write-one-to-clear) |
| sts_wdata | input | 1 | Data for the status write; 1 clears |
| ien_wr | input | 1 | Write strobe for the interrupt enable bit |
| ien_wdata | input | 1 | Value written to the interrupt enable bit |
| tmr_on | output | 1 | Current on-bit |
| preload_val | output | CNT_W | Current pre-load field |
| count_val | output | CNT_W | Current count |
| evt_sts | output | 1 | Sticky event status bit |
| evt_ien | output | 1 | Interrupt enable bit |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a status clear that arrives on exactly the edge where the count wraps, because that edge depends on both the count and the hidden prescaler phase. The bench gets there deterministically: it writes a pre-load of zero while the timer runs, which restarts the prescaler, then counts TICK_DIV-1 idle cycles and drives the clear strobe into the wrap edge. Random traffic with small pre-load values then produces many wraps that overlap random clears, on-bit toggles and pre-load writes, and a cycle-accurate bench model checks every output after each edge.

// File: rtl/pdt_pkg.sv
// Package: shared types for the periodic down-count timer.
// Assumes: nothing beyond IEEE 1800-2017.
package pdt_pkg;

    // One-bit register write request: strobe plus data.
    typedef struct packed {
        logic wr;
        logic data;
    } bitwr_t;

    // Divide ratio that gives one tick per 100 microseconds.
    function automatic int unsigned tick_div_for(input int unsigned clk_hz);
        return clk_hz / 10_000;
    endfunction

endpackage

// File: rtl/pdt_prescaler.sv
// Module: pdt_prescaler
// Divides the clock into a single-cycle tick every TICK_DIV cycles.
// Assumes: hold forces the phase back to zero and masks the tick; run gates all counting.
module pdt_prescaler #(
    parameter int unsigned TICK_DIV = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    output logic tick
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV <= 1) begin : g_nodiv
            // Tick on every enabled cycle that is not held.
            assign tick = run && !hold;
        end else begin : g_div
            logic [PW-1:0] phase_q;
            logic          last_w;

            assign last_w = (phase_q == PW'(TICK_DIV - 1));
            assign tick   = run && !hold && last_w;

            // Advance the phase counter; restart it on hold or while stopped.
            always_ff @(posedge clk) begin
                if (!rst_n || !run || hold)
                    phase_q <= '0;
                else if (last_w)
                    phase_q <= '0;
                else
                    phase_q <= phase_q + PW'(1);
            end

            // R3
            hold_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hold |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/pdt_counter.sv
// Module: pdt_counter
// Holds the on-bit, the pre-load field and the live count; handles load, restart, decrement and wrap.
// Assumes: tick comes from a prescaler that is held on every cycle in which load_o or stop_o is high.
module pdt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pdt_pkg::bitwr_t  on_req,
    input  logic             pre_wr,
    input  logic [CNT_W-1:0] pre_wdata,
    input  logic             tick,
    output logic             on_q,
    output logic [CNT_W-1:0] preload_q,
    output logic [CNT_W-1:0] count_q,
    output logic             load_o,
    output logic             stop_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic start_w;
    logic on_next_w;

    // Decode the on-bit edges requested this cycle.
    always_comb begin
        start_w   = on_req.wr && on_req.data && !on_q;
        stop_o    = on_req.wr && !on_req.data && on_q;
        on_next_w = on_req.wr ? on_req.data : on_q;
        load_o    = start_w || (pre_wr && on_next_w);
        wrap_o    = tick && (count_q == '0);
    end

    // On-bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= on_next_w;
    end

    // Pre-load field: all-ones on reset or switch-off, else software value.
    always_ff @(posedge clk) begin
        if (!rst_n)      preload_q <= ALL_ONES;
        else if (stop_o) preload_q <= ALL_ONES;
        else if (pre_wr) preload_q <= pre_wdata;
    end

    // Live count: load, wrap to all-ones, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= ALL_ONES;
        else if (load_o)
            count_q <= pre_wr ? pre_wdata : preload_q;
        else if (wrap_o)
            count_q <= ALL_ONES;
        else if (tick)
            count_q <= count_q - CNT_W'(1);
    end

    // R5
    wrap_to_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> count_q == ALL_ONES);
    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wrap_o |=> count_q == $past(count_q) - CNT_W'(1));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o && !tick |=> $stable(count_q));
    // R10
    off_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> preload_q == ALL_ONES && !on_q);
    // R9
    no_tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on_q |-> !tick);

endmodule

// File: rtl/pdt_irq_ctl.sv
// Module: pdt_irq_ctl
// Sticky write-one-to-clear status bit, interrupt enable bit and gated level request.
// Assumes: set_evt is a single-cycle pulse; a set beats a clear on the same edge.
module pdt_irq_ctl (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_evt,
    input  pdt_pkg::bitwr_t sts_req,
    input  pdt_pkg::bitwr_t ien_req,
    output logic            sts_q,
    output logic            ien_q,
    output logic            irq
);
    logic clr_w;

    assign clr_w = sts_req.wr && sts_req.data;

    // Status bit: set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       sts_q <= 1'b0;
        else if (set_evt) sts_q <= 1'b1;
        else if (clr_w)   sts_q <= 1'b0;
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          ien_q <= 1'b0;
        else if (ien_req.wr) ien_q <= ien_req.data;
    end

    // Level request from status gated by enable.
    assign irq = sts_q && ien_q;

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q && !clr_w |=> sts_q);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> sts_q);
    // R6
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w && !set_evt |=> !sts_q);

endmodule

// File: rtl/pdt_timer.sv
// Module: pdt_timer (top)
// Periodic 16-bit down-count timer stepping on a 100 us tick, with sticky interrupt status.
// Assumes: register writes arrive as single-cycle strobes synchronous to clk.
module pdt_timer #(
    parameter int unsigned CLK_HZ   = 200_000_000,
    parameter int unsigned TICK_DIV = pdt_pkg::tick_div_for(CLK_HZ),
    parameter int unsigned CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on_wr,
    input  logic             on_wdata,
    input  logic             pre_wr,
    input  logic [CNT_W-1:0] pre_wdata,
    input  logic             sts_wr,
    input  logic             sts_wdata,
    input  logic             ien_wr,
    input  logic             ien_wdata,
    output logic             tmr_on,
    output logic [CNT_W-1:0] preload_val,
    output logic [CNT_W-1:0] count_val,
    output logic             evt_sts,
    output logic             evt_ien,
    output logic             irq
);
    pdt_pkg::bitwr_t on_req, sts_req, ien_req;
    logic tick_w, load_w, stop_w, wrap_w;

    assign on_req  = '{wr: on_wr,  data: on_wdata};
    assign sts_req = '{wr: sts_wr, data: sts_wdata};
    assign ien_req = '{wr: ien_wr, data: ien_wdata};

    pdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tmr_on),
        .hold (load_w || stop_w),
        .tick (tick_w)
    );

    pdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .on_req   (on_req),
        .pre_wr   (pre_wr),
        .pre_wdata(pre_wdata),
        .tick     (tick_w),
        .on_q     (tmr_on),
        .preload_q(preload_val),
        .count_q  (count_val),
        .load_o   (load_w),
        .stop_o   (stop_w),
        .wrap_o   (wrap_w)
    );

    pdt_irq_ctl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(wrap_w),
        .sts_req(sts_req),
        .ien_req(ien_req),
        .sts_q  (evt_sts),
        .ien_q  (evt_ien),
        .irq    (irq)
    );

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> evt_sts && evt_ien);

endmodule

// File: tb/test_pdt_timer.sv
`timescale 1ns/1ps
// Bench for pdt_timer: directed corner cases, then seeded random traffic checked against a bench model.
module test_pdt_timer;
    localparam int D = 4;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on_wr = 0, on_wdata = 0, pre_wr = 0, sts_wr = 0, sts_wdata = 0, ien_wr = 0, ien_wdata = 0;
    logic [W-1:0] pre_wdata = '0;
    logic tmr_on, evt_sts, evt_ien, irq;
    logic [W-1:0] preload_val, count_val;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pdt_timer #(.TICK_DIV(D), .CNT_W(W)) i_pdt_timer (
        .clk(clk), .rst_n(rst_n), .on_wr(on_wr), .on_wdata(on_wdata),
        .pre_wr(pre_wr), .pre_wdata(pre_wdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata), .tmr_on(tmr_on), .preload_val(preload_val),
        .count_val(count_val), .evt_sts(evt_sts), .evt_ien(evt_ien), .irq(irq)
    );

    // Bench model state, built from the requirements.
    logic m_on, m_sts, m_ien;
    logic [W-1:0] m_pre, m_cnt;
    int m_ph;

    function automatic logic [W-1:0] next_count(logic [W-1:0] c);
        return (c == '0) ? '1 : c - 1'b1;   // R5 wrap, R3 step
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on <= 0; m_sts <= 0; m_ien <= 0; m_pre <= '1; m_cnt <= '1; m_ph <= 0;
        end else begin
            logic start, stop, onn, ld, tk;
            start = on_wr && on_wdata && !m_on;
            stop  = on_wr && !on_wdata && m_on;
            onn   = on_wr ? on_wdata : m_on;
            ld    = start || (pre_wr && onn);
            tk    = m_on && !ld && !stop && (m_ph == D-1);
            m_on  <= onn;
            m_ph  <= (!m_on || ld || stop || m_ph == D-1) ? 0 : m_ph + 1;
            if (stop) m_pre <= '1; else if (pre_wr) m_pre <= pre_wdata;
            if (ld) m_cnt <= pre_wr ? pre_wdata : m_pre;
            else if (tk) m_cnt <= next_count(m_cnt);
            if (tk && m_cnt == '0) m_sts <= 1;
            else if (sts_wr && sts_wdata) m_sts <= 0;
            if (ien_wr) m_ien <= ien_wdata;
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        on_wr = 0; pre_wr = 0; sts_wr = 0; ien_wr = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic cmp_model();
        check("R2 on-bit", {31'd0, tmr_on}, {31'd0, m_on});
        check("R4 preload", {16'd0, preload_val}, {16'd0, m_pre});
        check("R3 count", {16'd0, count_val}, {16'd0, m_cnt});
        check("R6 status", {31'd0, evt_sts}, {31'd0, m_sts});
        check("R8 irq", {31'd0, irq}, {31'd0, m_sts && m_ien});
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        void'($urandom(32'd20240611));
        @(negedge clk);
        idle(3);
        rst_n = 1;
        // R1 reset state
        check("R1 count", count_val, 16'hFFFF);
        check("R1 preload", preload_val, 16'hFFFF);
        check("R1 on", tmr_on, 0);
        check("R1 sts", evt_sts, 0);
        check("R1 ien", evt_ien, 0);
        check("R1 irq", irq, 0);

        // R4 pre-load write while off leaves count alone
        ien_wr = 1; ien_wdata = 1; pre_wr = 1; pre_wdata = 16'd3;
        cyc();
        check("R4 preload off", preload_val, 16'd3);
        check("R4 count off", count_val, 16'hFFFF);

        // R2 switch on loads the count
        on_wr = 1; on_wdata = 1;
        cyc();
        check("R2 load", count_val, 16'd3);
        idle(D-1);
        check("R3 before tick", count_val, 16'd3);
        cyc();
        check("R3 first step", count_val, 16'd2);

        // R5/R6/R8 wrap after three more ticks
        idle(3*D);
        check("R5 wrap", count_val, 16'hFFFF);
        check("R6 set", evt_sts, 1);
        check("R8 irq on", irq, 1);
        idle(D);
        check("R5 continue", count_val, 16'hFFFE);

        // R6 write 0 ignored, write 1 clears
        sts_wr = 1; sts_wdata = 0;
        cyc();
        check("R6 w0 ignored", evt_sts, 1);
        sts_wr = 1; sts_wdata = 1;
        cyc();
        check("R6 w1c", evt_sts, 0);
        check("R8 irq off", irq, 0);

        // R4 restart while on
        pre_wr = 1; pre_wdata = 16'd7;
        cyc();
        check("R4 restart", count_val, 16'd7);
        idle(D);
        check("R4 prescaler restart", count_val, 16'd6);

        // R7 clear strobe on the wrap edge
        pre_wr = 1; pre_wdata = 16'd0;
        cyc();
        idle(D-1);
        check("R7 pre-wrap", count_val, 16'd0);
        sts_wr = 1; sts_wdata = 1;
        cyc();
        check("R7 set wins", evt_sts, 1);
        check("R5 wrap direct", count_val, 16'hFFFF);

        // R9 switch off: pre-load to ones, count frozen, no events
        idle(2);
        held = count_val;
        on_wr = 1; on_wdata = 0;
        cyc();
        held = count_val;
        check("R9 preload ones", preload_val, 16'hFFFF);
        sts_wr = 1; sts_wdata = 1;
        cyc();
        pre_wr = 1; pre_wdata = 16'd0;
        cyc();
        idle(5*D);
        check("R9 frozen", count_val, held);
        check("R9 no event", evt_sts, 0);

        // R10 switch off and pre-load write on one edge
        on_wr = 1; on_wdata = 1;
        cyc();
        check("R2 load zero", count_val, 16'd0);
        on_wr = 1; on_wdata = 0; pre_wr = 1; pre_wdata = 16'd5;
        cyc();
        check("R10 preload ones", preload_val, 16'hFFFF);
        check("R10 off", tmr_on, 0);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            on_wr     = ($urandom % 100) < 3;
            on_wdata  = ($urandom % 100) < 70;
            pre_wr    = ($urandom % 100) < 4;
            pre_wdata = W'($urandom % 10);
            sts_wr    = ($urandom % 100) < 8;
            sts_wdata = $urandom % 2;
            ien_wr    = ($urandom % 100) < 3;
            ien_wdata = $urandom % 2;
            @(posedge clk);
            @(negedge clk);
            on_wr = 0; pre_wr = 0; sts_wr = 0; ien_wr = 0;
            cmp_model();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule